// File: doc/BRIEF.md
# Device Address Translation Unit

This block sits between a bus master that issues 32-bit device addresses and the memory system. Device addresses that fall inside a translation window at the very top of the 32-bit space are turned into 36-bit physical addresses. The translation comes from a single flat table of 32-bit entries held in memory, one entry for each 4 KiB page of the window. A four-way fully associative translation cache sits in front of the table, so that repeated accesses to a page do not need a table fetch. Software sets up the block through a small register port: it enables translation, sizes the window, points at the table, and flushes one cached page or all of them.

The window size is a power of two, from 16 MiB up to 2 GiB, and the window always ends at 0xFFFFFFFF. Each request gets exactly one response. The response carries either a physical address with a cacheable flag, or a fault. The request port stalls while a table entry is being fetched, and only one fetch is outstanding at a time.

Top module: `dvma_xlate_top`

## Requirements
- R1: After reset, req_ready is 1, resp_valid and mem_req are 0, and the control register reads with enable 0 and range 0, with the version code in bits 27:24 and the implementation code in bits 31:28.
- R2: Register address 0 is control: bit 0 is enable, bits 4:2 are the range field, and bits 31:24 are read-only codes. All other control bits read as 0. Register address 1 holds the table physical address shifted right by 4 in bits 27:0, and bits 31:28 read as 0.
- R3: While enable is 0, an accepted request is answered in the next cycle with resp_paddr equal to the zero-extended device address, no fault, resp_cache 0, and no memory read.
- R4: The window base is 2^32 − 16 MiB·2^range. An enabled request below the base is answered with a fault in the next cycle, and no memory read is made.
- R5: On a cache miss inside the window, exactly one memory read is issued. It is a one-cycle mem_req pulse in the cycle after acceptance, at address (table base << 4) + 4·((address − window base) >> 12). req_ready stays 0 until mem_rvalid, and the response follows in the next cycle.
- R6: A table entry carries the page number in bits 31:8, valid in bit 1, writable in bit 2 and cacheable in bit 7. A good translation returns {page number, address[11:0]}, and resp_cache is taken from bit 7.
- R7: A fetched entry with bit 1 clear, or a write request to an entry with bit 2 clear, gives a fault with resp_paddr 0 and resp_cache 0. An invalid entry is not cached. A read of a non-writable page succeeds.
- R8: A request that hits a cached translation is answered in the cycle after acceptance, and no memory read is made.
- R9: The cache holds four translations and fills them in round-robin order, so the fifth distinct fill replaces the first.
- R10: Writing a device address to register address 2 invalidates the cached translation of that page only.
- R11: Any write to register address 3 invalidates every cached translation.
- R12: A write to the table base register, or a control write that changes the range field, invalidates every cached translation. A control write that leaves the range unchanged does not.
- R13: If an invalidation occurs while a table fetch is outstanding, the response is still delivered from the fetched entry, but the entry is not installed in the cache.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 control, 1 table base, 2 page flush, 3 full flush) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| req_valid | input | 1 | Translation request present |
| req_addr | input | 32 | Device address |
| req_write | input | 1 | Request is a write |
| req_ready | output | 1 | Request accepted when high with req_valid |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_fault | output | 1 | Translation fault |
| resp_paddr | output | 36 | Physical address, 0 on a fault |
| resp_cache | output | 1 | Page is cacheable |
| mem_req | output | 1 | One-cycle table entry read request |
| mem_addr | output | 32 | Table entry address |
| mem_rvalid | input | 1 | Table entry data valid |
| mem_rdata | input | 32 | Table entry data |

## Verification
The assertions take three things for granted about the inputs. Memory answers each mem_req with exactly one single-cycle mem_rvalid, and only while a fetch is outstanding. A request is never presented in the same cycle as a register write that invalidates the cache. The bench memory model answers each read after a fixed two-cycle delay, from a pattern computed from the entry index. It drives requests only when req_ready is high, and it applies register writes either between transactions or, for the fetch-race case, while the block is stalled, where no request can be accepted.

// File: rtl/dvma_pkg.sv
`timescale 1ns/1ps
package dvma_pkg;

  localparam int VA_W         = 32;
  localparam int PG_W         = 12;
  localparam int VPN_W        = VA_W - PG_W;
  localparam int PPN_W        = 24;
  localparam int PA_W         = PPN_W + PG_W;
  localparam int RANGE_W      = 3;
  localparam int TBASE_W      = 28;
  localparam int WIN_MIN_LOG2 = 24;

  // table entry bit positions
  localparam int PTE_VLD_BIT  = 1;
  localparam int PTE_WR_BIT   = 2;
  localparam int PTE_C_BIT    = 7;
  localparam int PTE_PPN_LSB  = 8;

  // control register bit positions
  localparam int CTL_EN_BIT   = 0;
  localparam int CTL_RNG_LSB  = 2;

  typedef enum logic [1:0] {
    RA_CTRL      = 2'd0,
    RA_TBASE     = 2'd1,
    RA_FLUSH_PG  = 2'd2,
    RA_FLUSH_ALL = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic [PPN_W-1:0] ppn;
    logic             wr_ok;
    logic             cache;
    logic             vld;
  } pte_t;

  typedef struct packed {
    logic             vld;
    logic [VPN_W-1:0] vpn;
    logic [PPN_W-1:0] ppn;
    logic             wr_ok;
    logic             cache;
  } tlb_ent_t;

  function automatic pte_t decode_pte(input logic [31:0] d);
    pte_t p;
    p.ppn   = d[PTE_PPN_LSB +: PPN_W];
    p.wr_ok = d[PTE_WR_BIT];
    p.cache = d[PTE_C_BIT];
    p.vld   = d[PTE_VLD_BIT];
    return p;
  endfunction

  // window covers the top 2^(24+rng) bytes: all bits above that are ones
  function automatic logic in_window(input logic [VA_W-1:0] a,
                                     input logic [RANGE_W-1:0] rng);
    logic [VA_W-1:0] upper;
    upper = (~a) >> (6'(WIN_MIN_LOG2) + 6'(rng));
    return upper == '0;
  endfunction

  // entry address: table base plus four bytes per page of window offset
  function automatic logic [31:0] pte_addr(input logic [TBASE_W-1:0] tb,
                                           input logic [VA_W-1:0] a,
                                           input logic [RANGE_W-1:0] rng);
    logic [VPN_W-1:0] keep;
    logic [VPN_W-1:0] idx;
    keep = ~({VPN_W{1'b1}} << (5'(WIN_MIN_LOG2 - PG_W) + 5'(rng)));
    idx  = a[VA_W-1:PG_W] & keep;
    return {tb, 4'b0000} + {10'b0, idx, 2'b00};
  endfunction

endpackage

// File: rtl/dvma_regs.sv
`timescale 1ns/1ps
module dvma_regs
  import dvma_pkg::*;
#(
  parameter logic [3:0] VER_CODE  = 4'h2,
  parameter logic [3:0] IMPL_CODE = 4'h5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [1:0]         addr,
  input  logic [31:0]        wdata,
  output logic [31:0]        rdata,
  output logic               en_o,
  output logic [RANGE_W-1:0] rng_o,
  output logic [TBASE_W-1:0] tbase_o,
  output logic               inv_all_o,
  output logic               inv_page_o,
  output logic [VPN_W-1:0]   inv_vpn_o
);

  logic               en_q;
  logic [RANGE_W-1:0] rng_q;
  logic [TBASE_W-1:0] tbase_q;
  logic [RANGE_W-1:0] new_rng;

  assign new_rng = wdata[CTL_RNG_LSB +: RANGE_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      rng_q   <= '0;
      tbase_q <= '0;
    end else if (wr_en) begin
      if (addr == RA_CTRL) begin
        en_q  <= wdata[CTL_EN_BIT];
        rng_q <= new_rng;
      end
      if (addr == RA_TBASE) tbase_q <= wdata[TBASE_W-1:0];
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      RA_CTRL: begin
        rdata[31:28]                     = IMPL_CODE;
        rdata[27:24]                     = VER_CODE;
        rdata[CTL_RNG_LSB +: RANGE_W]    = rng_q;
        rdata[CTL_EN_BIT]                = en_q;
      end
      RA_TBASE: rdata[TBASE_W-1:0] = tbase_q;
      default:  rdata = '0;
    endcase
  end

  assign inv_all_o  = wr_en && ((addr == RA_FLUSH_ALL) || (addr == RA_TBASE) ||
                                ((addr == RA_CTRL) && (new_rng != rng_q)));
  assign inv_page_o = wr_en && (addr == RA_FLUSH_PG);
  assign inv_vpn_o  = wdata[VA_W-1:PG_W];
  assign en_o       = en_q;
  assign rng_o      = rng_q;
  assign tbase_o    = tbase_q;

endmodule

// File: rtl/dvma_tlb.sv
`timescale 1ns/1ps
module dvma_tlb
  import dvma_pkg::*;
#(
  parameter int WAYS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VPN_W-1:0] look_vpn,
  input  logic             inv_all,
  input  logic             inv_page,
  input  logic [VPN_W-1:0] inv_vpn,
  input  logic             fill_en,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PPN_W-1:0] fill_ppn,
  input  logic             fill_w,
  input  logic             fill_c,
  output logic [WAYS-1:0]  hit_vec,
  output logic [WAYS-1:0]  vld_vec,
  output logic             hit,
  output logic [PPN_W-1:0] hit_ppn,
  output logic             hit_w,
  output logic             hit_c
);

  localparam int PTR_W = (WAYS > 1) ? $clog2(WAYS) : 1;

  logic [PTR_W-1:0]            ptr_q;
  logic [WAYS-1:0][PPN_W-1:0]  way_ppn;
  logic [WAYS-1:0]             way_w;
  logic [WAYS-1:0]             way_c;

  for (genvar g = 0; g < WAYS; g++) begin : g_way
    tlb_ent_t e_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        e_q <= '0;
      end else if (inv_all || (inv_page && (e_q.vpn == inv_vpn))) begin
        e_q.vld <= 1'b0;
      end else if (fill_en && (ptr_q == PTR_W'(g))) begin
        e_q.vld   <= 1'b1;
        e_q.vpn   <= fill_vpn;
        e_q.ppn   <= fill_ppn;
        e_q.wr_ok <= fill_w;
        e_q.cache <= fill_c;
      end
    end
    assign hit_vec[g] = e_q.vld && (e_q.vpn == look_vpn);
    assign vld_vec[g] = e_q.vld;
    assign way_ppn[g] = e_q.ppn;
    assign way_w[g]   = e_q.wr_ok;
    assign way_c[g]   = e_q.cache;
  end

  always_comb begin
    hit_ppn = '0;
    hit_w   = 1'b0;
    hit_c   = 1'b0;
    for (int i = 0; i < WAYS; i++) begin
      if (hit_vec[i]) begin
        hit_ppn = hit_ppn | way_ppn[i];
        hit_w   = hit_w | way_w[i];
        hit_c   = hit_c | way_c[i];
      end
    end
  end

  assign hit = |hit_vec;

  always_ff @(posedge clk) begin
    if (!rst_n)       ptr_q <= '0;
    else if (fill_en) ptr_q <= (ptr_q == PTR_W'(WAYS - 1)) ? '0 : ptr_q + 1'b1;
  end

endmodule

// File: rtl/dvma_walk.sv
`timescale 1ns/1ps
module dvma_walk
  import dvma_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [VA_W-1:0]    req_addr,
  input  logic               req_write,
  output logic               req_ready,
  output logic               resp_valid,
  output logic               resp_fault,
  output logic [PA_W-1:0]    resp_paddr,
  output logic               resp_cache,
  output logic               mem_req,
  output logic [31:0]        mem_addr,
  input  logic               mem_rvalid,
  input  logic [31:0]        mem_rdata,
  input  logic               en,
  input  logic [RANGE_W-1:0] rng,
  input  logic [TBASE_W-1:0] tbase,
  input  logic               hit,
  input  logic [PPN_W-1:0]   hit_ppn,
  input  logic               hit_w,
  input  logic               hit_c,
  input  logic               inv_any,
  output logic               fill_en,
  output logic [VPN_W-1:0]   fill_vpn,
  output logic [PPN_W-1:0]   fill_ppn,
  output logic               fill_w,
  output logic               fill_c,
  output logic               acc_evt,
  output logic               ret_evt
);

  typedef enum logic {ST_IDLE, ST_WAIT} st_e;

  st_e              st_q;
  logic [VA_W-1:0]  pend_addr_q;
  logic             pend_wr_q;
  logic             drop_q;
  logic             win_ok;
  logic             need_walk;
  pte_t             fetched;
  logic             r_fault;
  logic [PA_W-1:0]  r_pa;
  logic             r_c;
  logic             resp_valid_q, resp_fault_q, resp_cache_q, mem_req_q;
  logic [PA_W-1:0]  resp_pa_q;
  logic [31:0]      mem_addr_q;

  assign fetched   = decode_pte(mem_rdata);
  assign req_ready = (st_q == ST_IDLE);
  assign acc_evt   = req_valid && req_ready;
  assign ret_evt   = (st_q == ST_WAIT) && mem_rvalid;
  assign win_ok    = in_window(req_addr, rng);
  assign need_walk = acc_evt && en && win_ok && !hit;

  assign fill_en   = ret_evt && fetched.vld && !drop_q && !inv_any;
  assign fill_vpn  = pend_addr_q[VA_W-1:PG_W];
  assign fill_ppn  = fetched.ppn;
  assign fill_w    = fetched.wr_ok;
  assign fill_c    = fetched.cache;

  always_comb begin
    r_fault = 1'b0;
    r_pa    = '0;
    r_c     = 1'b0;
    if (ret_evt) begin
      if (!fetched.vld || (pend_wr_q && !fetched.wr_ok)) r_fault = 1'b1;
      else begin
        r_pa = {fetched.ppn, pend_addr_q[PG_W-1:0]};
        r_c  = fetched.cache;
      end
    end else if (!en) begin
      r_pa = {{(PA_W-VA_W){1'b0}}, req_addr};
    end else if (!win_ok || (req_write && !hit_w)) begin
      r_fault = 1'b1;
    end else begin
      r_pa = {hit_ppn, req_addr[PG_W-1:0]};
      r_c  = hit_c;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q         <= ST_IDLE;
      pend_addr_q  <= '0;
      pend_wr_q    <= 1'b0;
      drop_q       <= 1'b0;
      resp_valid_q <= 1'b0;
      resp_fault_q <= 1'b0;
      resp_pa_q    <= '0;
      resp_cache_q <= 1'b0;
      mem_req_q    <= 1'b0;
      mem_addr_q   <= '0;
    end else begin
      resp_valid_q <= ret_evt || (acc_evt && !need_walk);
      mem_req_q    <= need_walk;
      if (ret_evt || acc_evt) begin
        resp_fault_q <= r_fault;
        resp_pa_q    <= r_pa;
        resp_cache_q <= r_c;
      end
      if (need_walk) begin
        st_q        <= ST_WAIT;
        pend_addr_q <= req_addr;
        pend_wr_q   <= req_write;
        drop_q      <= 1'b0;
        mem_addr_q  <= pte_addr(tbase, req_addr, rng);
      end else if (ret_evt) begin
        st_q <= ST_IDLE;
      end else if ((st_q == ST_WAIT) && inv_any) begin
        drop_q <= 1'b1;
      end
    end
  end

  assign resp_valid = resp_valid_q;
  assign resp_fault = resp_fault_q;
  assign resp_paddr = resp_pa_q;
  assign resp_cache = resp_cache_q;
  assign mem_req    = mem_req_q;
  assign mem_addr   = mem_addr_q;

endmodule

// File: rtl/dvma_xlate_top.sv
`timescale 1ns/1ps
module dvma_xlate_top
  import dvma_pkg::*;
#(
  parameter int         WAYS      = 4,
  parameter logic [3:0] VER_CODE  = 4'h2,
  parameter logic [3:0] IMPL_CODE = 4'h5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        req_valid,
  input  logic [31:0] req_addr,
  input  logic        req_write,
  output logic        req_ready,
  output logic        resp_valid,
  output logic        resp_fault,
  output logic [35:0] resp_paddr,
  output logic        resp_cache,
  output logic        mem_req,
  output logic [31:0] mem_addr,
  input  logic        mem_rvalid,
  input  logic [31:0] mem_rdata
);

  logic               en;
  logic [RANGE_W-1:0] rng;
  logic [TBASE_W-1:0] tbase;
  logic               inv_all, inv_page, inv_any;
  logic [VPN_W-1:0]   inv_vpn;
  logic [WAYS-1:0]    hit_vec, vld_vec;
  logic               hit, hit_w, hit_c;
  logic [PPN_W-1:0]   hit_ppn;
  logic               fill_en, fill_w, fill_c;
  logic [VPN_W-1:0]   fill_vpn;
  logic [PPN_W-1:0]   fill_ppn;
  logic               acc_evt, ret_evt;

  assign inv_any = inv_all || inv_page;

  dvma_regs #(.VER_CODE(VER_CODE), .IMPL_CODE(IMPL_CODE)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .en_o(en), .rng_o(rng), .tbase_o(tbase),
    .inv_all_o(inv_all), .inv_page_o(inv_page), .inv_vpn_o(inv_vpn)
  );

  dvma_tlb #(.WAYS(WAYS)) u_tlb (
    .clk(clk), .rst_n(rst_n), .look_vpn(req_addr[VA_W-1:PG_W]),
    .inv_all(inv_all), .inv_page(inv_page), .inv_vpn(inv_vpn),
    .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
    .fill_w(fill_w), .fill_c(fill_c), .hit_vec(hit_vec), .vld_vec(vld_vec),
    .hit(hit), .hit_ppn(hit_ppn), .hit_w(hit_w), .hit_c(hit_c)
  );

  dvma_walk u_walk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_write(req_write), .req_ready(req_ready), .resp_valid(resp_valid),
    .resp_fault(resp_fault), .resp_paddr(resp_paddr), .resp_cache(resp_cache),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .en(en), .rng(rng), .tbase(tbase), .hit(hit),
    .hit_ppn(hit_ppn), .hit_w(hit_w), .hit_c(hit_c), .inv_any(inv_any),
    .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
    .fill_w(fill_w), .fill_c(fill_c), .acc_evt(acc_evt), .ret_evt(ret_evt)
  );

endmodule

// File: rtl/dvma_xlate_chk.sv
`timescale 1ns/1ps
module dvma_xlate_chk #(
  parameter int WAYS = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_ready,
  input logic            resp_valid,
  input logic            resp_fault,
  input logic [35:0]     resp_paddr,
  input logic            resp_cache,
  input logic            mem_req,
  input logic            acc_evt,
  input logic            ret_evt,
  input logic            hit,
  input logic            en,
  input logic            inv_all,
  input logic [WAYS-1:0] hit_vec,
  input logic [WAYS-1:0] vld_vec
);

  p_hit_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  p_hit_nomem_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_evt && en && hit) |=> (resp_valid && !mem_req));

  p_mem_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);

  p_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !req_ready);

  p_fill_resp_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ret_evt |=> (resp_valid && req_ready));

  p_resp_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> ($past(acc_evt) || $past(ret_evt)));

  p_bypass_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_evt && !en) |=> (resp_valid && !resp_fault && !resp_cache && !mem_req));

  p_fault_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_fault) |-> (resp_paddr == '0 && !resp_cache));

  p_flush_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all |=> (vld_vec == '0));

endmodule

bind dvma_xlate_top dvma_xlate_chk #(.WAYS(WAYS)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .resp_valid(resp_valid),
  .resp_fault(resp_fault), .resp_paddr(resp_paddr), .resp_cache(resp_cache),
  .mem_req(mem_req), .acc_evt(acc_evt), .ret_evt(ret_evt), .hit(hit), .en(en),
  .inv_all(inv_all), .hit_vec(hit_vec), .vld_vec(vld_vec)
);

// File: tb/tb_dvma_xlate_top.sv
`timescale 1ns/1ps
module tb_dvma_xlate_top;

  localparam logic [31:0] TB_PA   = 32'h0010_0000;
  localparam int          MEM_LAT = 2;
  localparam int          NV      = 13;
  // {address, write, expect a table read}
  localparam logic [33:0] VEC [NV] = '{
    {32'hFC00_0123, 1'b0, 1'b1},  // page 0 fill
    {32'hFC00_0FFF, 1'b1, 1'b0},  // hit, writable
    {32'hFC00_1010, 1'b0, 1'b1},  // page 1 cacheable
    {32'hFC00_6000, 1'b0, 1'b1},  // read-only page read
    {32'hFC00_6004, 1'b1, 1'b0},  // write to read-only hit: fault
    {32'hFC00_7000, 1'b0, 1'b1},  // invalid entry
    {32'hFC00_7000, 1'b0, 1'b1},  // invalid entry not cached
    {32'hFBFF_FFFF, 1'b0, 1'b0},  // R4 just below window
    {32'hFFFF_EABC, 1'b1, 1'b1},  // top of window, read-only write
    {32'hFC00_0456, 1'b0, 1'b0},  // page 0 still cached
    {32'hFC00_2000, 1'b0, 1'b1},  // fifth fill replaces page 0
    {32'hFC00_0000, 1'b0, 1'b1},  // R9 page 0 was evicted
    {32'hFC00_6800, 1'b0, 1'b0}   // page 6 survives
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic        req_ready, resp_valid, resp_fault, resp_cache, mem_req;
  logic [35:0] resp_paddr;
  logic [31:0] mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;

  int          n_chk = 0;
  int          n_bad = 0;
  int          mem_reads = 0;
  logic [31:0] last_maddr = '0;

  always #4 clk = ~clk;

  dvma_xlate_top #(.WAYS(4), .VER_CODE(4'h2), .IMPL_CODE(4'h5)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_valid(req_valid),
    .req_addr(req_addr), .req_write(req_write), .req_ready(req_ready),
    .resp_valid(resp_valid), .resp_fault(resp_fault), .resp_paddr(resp_paddr),
    .resp_cache(resp_cache), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  // table contents: page number 0xA50000+index; index%8==7 invalid,
  // index%8==6 read-only, odd index cacheable
  function automatic logic [31:0] pte_of(input int unsigned idx);
    logic [23:0] ppn;
    ppn = 24'hA5_0000 + idx[23:0];
    return {ppn, (idx % 2 == 1), 4'b0000, (idx % 8 != 6), (idx % 8 != 7), 1'b0};
  endfunction

  task automatic model(input logic [31:0] a, input bit wr, input int rng,
                       output bit flt, output logic [35:0] pa, output bit c,
                       output logic [31:0] eaddr);
    longint unsigned base, idx;
    logic [31:0] e;
    base = 64'h1_0000_0000 - (64'h100_0000 << rng);
    flt = 1'b0; pa = '0; c = 1'b0; eaddr = '0;
    if (longint'(a) < base) begin
      flt = 1'b1;
    end else begin
      idx   = (longint'(a) - base) / 4096;
      eaddr = TB_PA + 32'(idx * 4);
      e     = pte_of(int'(idx));
      if (!e[1] || (wr && !e[2])) flt = 1'b1;
      else begin
        pa = {e[31:8], a[11:0]};
        c  = e[7];
      end
    end
  endtask

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic do_req(input logic [31:0] a, input bit wr, output bit f,
                        output logic [35:0] p, output bit c, output int lat,
                        output int nr);
    int r0;
    r0 = mem_reads;
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_write = wr;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (!resp_valid && lat < 50) begin
      @(negedge clk);
      lat++;
    end
    f = resp_fault; p = resp_paddr; c = resp_cache;
    nr = mem_reads - r0;
  endtask

  task automatic run_one(input logic [31:0] a, input bit wr, input int rng,
                         input bit exp_miss, input string tag);
    bit ef, ec, f, c;
    logic [35:0] ep, p;
    logic [31:0] ea;
    int lat, nr;
    model(a, wr, rng, ef, ep, ec, ea);
    do_req(a, wr, f, p, c, lat, nr);
    chk(f == ef, {tag, " R7 fault"}, 64'(f), 64'(ef));
    chk(p == ep, {tag, " R6 paddr"}, 64'(p), 64'(ep));
    chk(c == ec, {tag, " R6 cache"}, 64'(c), 64'(ec));
    chk(nr == int'(exp_miss), {tag, " R8 table reads"}, 64'(nr), 64'(exp_miss));
    if (exp_miss) begin
      chk(last_maddr == ea, {tag, " R5 entry address"}, 64'(last_maddr), 64'(ea));
      chk(lat == MEM_LAT + 2, {tag, " R5 miss latency"}, 64'(lat), 64'(MEM_LAT + 2));
    end else begin
      chk(lat == 1, {tag, " R8 latency"}, 64'(lat), 64'd1);
    end
  endtask

  // memory model: fixed-latency single-beat reply to each table read
  initial begin
    forever begin
      @(negedge clk);
      if (mem_req === 1'b1) begin
        mem_reads++;
        last_maddr = mem_addr;
        repeat (MEM_LAT) @(negedge clk);
        mem_rvalid = 1'b1;
        mem_rdata  = pte_of((last_maddr - TB_PA) >> 2);
        @(negedge clk);
        mem_rvalid = 1'b0;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] rd;
    bit f, c;
    logic [35:0] p;
    int lat, nr;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(req_ready == 1'b1, "R1 req_ready", 64'(req_ready), 64'd1);
    chk(resp_valid == 1'b0, "R1 resp_valid", 64'(resp_valid), 64'd0);
    chk(mem_req == 1'b0, "R1 mem_req", 64'(mem_req), 64'd0);
    reg_read(2'd0, rd);
    chk(rd == 32'h5200_0000, "R1 control reset", 64'(rd), 64'h5200_0000);

    // R2 register fields
    reg_write(2'd0, 32'hA0B0_000B);
    reg_read(2'd0, rd);
    chk(rd == 32'h5200_0009, "R2 control readback", 64'(rd), 64'h5200_0009);
    reg_write(2'd1, 32'hF001_0000);
    reg_read(2'd1, rd);
    chk(rd == 32'h0001_0000, "R2 table base readback", 64'(rd), 64'h0001_0000);
    @(negedge clk);

    // vector table, 64 MiB window
    for (int i = 0; i < NV; i++) begin
      run_one(VEC[i][33:2], VEC[i][1], 2, VEC[i][0], $sformatf("vec%0d", i));
    end

    // R10 page flush removes page 6 only
    reg_write(2'd2, 32'hFC00_6ABC);
    run_one(32'hFC00_6000, 1'b0, 2, 1'b1, "R10 flushed page");
    run_one(32'hFC00_2000, 1'b0, 2, 1'b0, "R10 other page kept");

    // R11 full flush
    reg_write(2'd3, 32'h0);
    run_one(32'hFC00_2000, 1'b0, 2, 1'b1, "R11 after flush");

    // R12 same range keeps, table base write and range change flush
    reg_write(2'd0, 32'h0000_0009);
    run_one(32'hFC00_2000, 1'b0, 2, 1'b0, "R12 same range");
    reg_write(2'd1, 32'h0001_0000);
    run_one(32'hFC00_2000, 1'b0, 2, 1'b1, "R12 table base write");
    reg_write(2'd0, 32'h0000_000D);
    run_one(32'hFC00_2000, 1'b0, 3, 1'b1, "R12 range change");
    run_one(32'hF800_0010, 1'b1, 3, 1'b1, "R4 new window base");
    run_one(32'hF7FF_FFFF, 1'b0, 3, 1'b0, "R4 below new base");
    reg_write(2'd0, 32'h0000_0009);

    // R13 flush while a fetch is outstanding
    fork
      run_one(32'hFC00_3000, 1'b0, 2, 1'b1, "R13 racing fetch");
      begin
        repeat (2) @(negedge clk);
        reg_write(2'd3, 32'h0);
      end
    join
    run_one(32'hFC00_3000, 1'b0, 2, 1'b1, "R13 not installed");

    // R3 bypass when disabled
    reg_write(2'd0, 32'h0000_0008);
    do_req(32'h1234_5678, 1'b1, f, p, c, lat, nr);
    chk(!f, "R3 no fault", 64'(f), 64'd0);
    chk(p == 36'h0_1234_5678, "R3 passthrough", 64'(p), 64'h1234_5678);
    chk(!c && nr == 0 && lat == 1, "R3 no read one cycle",
        64'({c, 8'(nr), 8'(lat)}), 64'h1);

    finish_run();
  end

endmodule